// File: doc/BRIEF.md
# Two-Wire Controller Host Register File

This block is the processor-facing register file of a controller that connects a parallel host bus to a two-wire serial bus. The host picks one of four register slots with a 2-bit address and a write or read strobe. The slots give access to five registers: status, time-out, data, own-address and control. The block holds the reset values and drives an active-low interrupt line. It applies the hardware side effects on the interrupt-request bit (SI) and the stop-request bit (STO).

The protocol engine connects to the other side of the block. It receives the control fields, the time-out value, the own address and the data byte to transmit. It reports new status codes and pulses that set SI or clear STO. It writes received bytes into the data register over a valid/ready capture port. `eng_cap_ready` is high only while SI is clear. The engine holds `eng_cap_valid` and `eng_cap_data` until a cycle in which ready is high, and the byte is taken on that edge. While SI is set, ready stays low and the data byte is frozen for the host to read.

After the enable bit is written to 1, a parameterised start-up count runs. A ready flag tells the engine when it may begin master or slave operation. The serial shifter and the bus state machine are outside this block.

Top module: `twi_host_regs`

## Requirements
- R1: After reset the status register reads 0xF8, the time-out register holds 0xFF, and data, own-address and control read 0x00. `irq_n` is 1 and `eng_ready` is 0.
- R2: Address decoding is as follows. Address 0 reads status and writes the time-out register. Address 1 is data, address 2 is own-address and address 3 is control. `hst_rdata` shows the selected register combinationally while `hst_rd` is 1, and 0x00 otherwise.
- R3: The control bits are laid out as follows. Bit 7 is ack-enable, bit 6 is enable, bit 5 is start request, bit 4 is stop request, bit 3 is SI and bits 2:0 are the rate field. Each field appears on its own `cfg_*` output.
- R4: Any host write to control clears SI, whatever value is written to bit 3. The exception is an `eng_si_set` pulse in the same cycle, which wins.
- R5: `eng_si_set` sets SI when enable is 1 and has no effect when enable is 0.
- R6: `eng_sto_clr` clears the stop bit. It takes priority over a host write of 1 to that bit in the same cycle.
- R7: `irq_n` is 0 exactly when SI and enable are both 1.
- R8: A host write to the data register is accepted only while SI is 1. While SI is 0 the write is ignored.
- R9: `eng_cap_ready` equals the inverse of SI. A cycle with `eng_cap_valid` and `eng_cap_ready` both high loads `eng_cap_data` into the data register. While SI is 1 the data register changes only through host writes.
- R10: The status register loads `eng_stat` on `eng_stat_we`. Host writes to address 0 never change it.
- R11: `eng_ready` goes to 1 exactly STARTUP_CYCLES clock edges after the edge that sets enable. It is 0 whenever enable is 0, and `eng_hold` equals the inverse of enable.
- R12: Own-address bits 7:1 drive `cfg_own_addr`. All 8 bits, bit 0 included, read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 2 | Register slot select |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data |
| irq_n | output | 1 | Active-low interrupt |
| eng_stat_we | input | 1 | Status load strobe from engine |
| eng_stat | input | 8 | Status code from engine |
| eng_si_set | input | 1 | Request to set SI |
| eng_sto_clr | input | 1 | Stop condition seen, clear stop bit |
| eng_cap_valid | input | 1 | Capture byte valid |
| eng_cap_ready | output | 1 | Capture port ready (SI clear) |
| eng_cap_data | input | 8 | Captured byte |
| tx_data | output | 8 | Data register contents |
| cfg_timeout | output | 8 | Time-out register contents |
| cfg_own_addr | output | 7 | 7-bit own slave address |
| cfg_ack_en | output | 1 | Ack-enable control bit |
| cfg_enable | output | 1 | Enable control bit |
| cfg_start | output | 1 | Start request bit |
| cfg_stop | output | 1 | Stop request bit |
| cfg_si | output | 1 | Interrupt-request flag |
| cfg_rate | output | 3 | Rate select field |
| eng_ready | output | 1 | Start-up delay elapsed |
| eng_hold | output | 1 | Engine held in not-addressed idle |

## Verification
The bench builds the block with STARTUP_CYCLES set to 8 in place of the default of several tens of thousands. This lets it observe the exact edge on which `eng_ready` rises and confirm that it stays low on every earlier edge. With the short count, the bench can also clear and re-set enable several times within a short run. The capture port and the host data path are driven with SI in both states, so that both the data freeze and the host-write gate are reached.

// File: rtl/twi_regs_pkg.sv
package twi_regs_pkg;

  typedef enum logic [1:0] {
    SLOT_STAT_TO = 2'd0,
    SLOT_DATA    = 2'd1,
    SLOT_OWN     = 2'd2,
    SLOT_CTRL    = 2'd3
  } slot_e;

  typedef struct packed {
    logic       ack_en;
    logic       enable;
    logic       start;
    logic       stop;
    logic       si;
    logic [2:0] rate;
  } ctrl_t;

  localparam logic [7:0] STAT_RESET = 8'hF8;
  localparam logic [7:0] TO_RESET   = 8'hFF;

endpackage

// File: rtl/twi_ctrl_reg.sv
module twi_ctrl_reg
  import twi_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       si_set,
  input  logic       sto_clr,
  output ctrl_t      q
);

  ctrl_t nxt;

  always_comb begin
    nxt = q;
    if (wr_en) begin
      nxt    = ctrl_t'(wdata);
      nxt.si = 1'b0;
    end
    if (sto_clr) nxt.stop = 1'b0;
    if (si_set && q.enable) nxt.si = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_SI_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !si_set) |=> !q.si); // R4
  AST_SI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !q.enable |-> !q.si); // R5
  AST_STO_HW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    sto_clr |=> !q.stop); // R6

endmodule

// File: rtl/twi_data_reg.sv
module twi_data_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          si,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          cap_valid,
  output logic          cap_ready,
  input  logic [DW-1:0] cap_data,
  output logic [DW-1:0] q
);

  logic host_take;
  logic cap_take;

  assign cap_ready = ~si;
  assign host_take = host_wr & si;
  assign cap_take  = cap_valid & cap_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         q <= '0;
    else if (host_take) q <= host_wdata;
    else if (cap_take)  q <= cap_data;
  end

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (si && !host_wr) |=> $stable(q)); // R9
  AST_DATA_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!si && !cap_valid) |=> $stable(q)); // R8

endmodule

// File: rtl/twi_startup_timer.sv
module twi_startup_timer #(
  parameter int STARTUP_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic ready
);

  localparam int CW = $clog2(STARTUP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign ready = enable & (cnt == LAST);

  AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> enable); // R11
  AST_READY_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && enable) |=> (ready || !enable)); // R11

endmodule

// File: rtl/twi_host_regs.sv
module twi_host_regs
  import twi_regs_pkg::*;
#(
  parameter int STARTUP_CYCLES = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hst_addr,
  input  logic       hst_wr,
  input  logic       hst_rd,
  input  logic [7:0] hst_wdata,
  output logic [7:0] hst_rdata,
  output logic       irq_n,
  input  logic       eng_stat_we,
  input  logic [7:0] eng_stat,
  input  logic       eng_si_set,
  input  logic       eng_sto_clr,
  input  logic       eng_cap_valid,
  output logic       eng_cap_ready,
  input  logic [7:0] eng_cap_data,
  output logic [7:0] tx_data,
  output logic [7:0] cfg_timeout,
  output logic [6:0] cfg_own_addr,
  output logic       cfg_ack_en,
  output logic       cfg_enable,
  output logic       cfg_start,
  output logic       cfg_stop,
  output logic       cfg_si,
  output logic [2:0] cfg_rate,
  output logic       eng_ready,
  output logic       eng_hold
);

  slot_e slot;
  logic  wr_to, wr_data, wr_own, wr_ctrl;
  logic [7:0] status_q, timeout_q, own_q;
  ctrl_t ctrl_q;

  assign slot    = slot_e'(hst_addr);
  assign wr_to   = hst_wr && (slot == SLOT_STAT_TO);
  assign wr_data = hst_wr && (slot == SLOT_DATA);
  assign wr_own  = hst_wr && (slot == SLOT_OWN);
  assign wr_ctrl = hst_wr && (slot == SLOT_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q  <= STAT_RESET;
      timeout_q <= TO_RESET;
      own_q     <= '0;
    end else begin
      if (eng_stat_we) status_q  <= eng_stat;
      if (wr_to)       timeout_q <= hst_wdata;
      if (wr_own)      own_q     <= hst_wdata;
    end
  end

  twi_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ctrl),
    .wdata   (hst_wdata),
    .si_set  (eng_si_set),
    .sto_clr (eng_sto_clr),
    .q       (ctrl_q)
  );

  twi_data_reg #(.DW(8)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .si         (ctrl_q.si),
    .host_wr    (wr_data),
    .host_wdata (hst_wdata),
    .cap_valid  (eng_cap_valid),
    .cap_ready  (eng_cap_ready),
    .cap_data   (eng_cap_data),
    .q          (tx_data)
  );

  twi_startup_timer #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (ctrl_q.enable),
    .ready  (eng_ready)
  );

  always_comb begin
    hst_rdata = '0;
    if (hst_rd) begin
      unique case (slot)
        SLOT_STAT_TO: hst_rdata = status_q;
        SLOT_DATA:    hst_rdata = tx_data;
        SLOT_OWN:     hst_rdata = own_q;
        SLOT_CTRL:    hst_rdata = ctrl_q;
        default:      hst_rdata = '0;
      endcase
    end
  end

  assign irq_n        = ~(ctrl_q.si & ctrl_q.enable);
  assign cfg_timeout  = timeout_q;
  assign cfg_own_addr = own_q[7:1];
  assign cfg_ack_en   = ctrl_q.ack_en;
  assign cfg_enable   = ctrl_q.enable;
  assign cfg_start    = ctrl_q.start;
  assign cfg_stop     = ctrl_q.stop;
  assign cfg_si       = ctrl_q.si;
  assign cfg_rate     = ctrl_q.rate;
  assign eng_hold     = ~ctrl_q.enable;

  AST_STATUS_HOST_RO: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_stat_we |=> $stable(status_q)); // R10
  AST_TO_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_to |=> $stable(cfg_timeout)); // R2
  AST_IRQ_FOLLOWS_SI: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n) |-> (cfg_si && cfg_enable)); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_rd |-> (hst_rdata == 8'h00)); // R2

endmodule

// File: tb/tb_twi_host_regs.sv
module tb_twi_host_regs;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] hst_addr = '0;
  logic       hst_wr = 1'b0, hst_rd = 1'b0;
  logic [7:0] hst_wdata = '0, hst_rdata;
  logic       irq_n;
  logic       eng_stat_we = 1'b0;
  logic [7:0] eng_stat = '0;
  logic       eng_si_set = 1'b0, eng_sto_clr = 1'b0;
  logic       eng_cap_valid = 1'b0, eng_cap_ready;
  logic [7:0] eng_cap_data = '0, tx_data, cfg_timeout;
  logic [6:0] cfg_own_addr;
  logic       cfg_ack_en, cfg_enable, cfg_start, cfg_stop, cfg_si;
  logic [2:0] cfg_rate;
  logic       eng_ready, eng_hold;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  twi_host_regs #(.STARTUP_CYCLES(N)) dut (.*);

  // {write, addr, data, expected read}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h5A, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'hF8},
    {1'b1, 2'd2, 8'hA4, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'hA4},
    {1'b1, 2'd1, 8'h77, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h00},
    {1'b1, 2'd3, 8'hFF, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'hF7},
    {1'b1, 2'd3, 8'h08, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_rd = 1'b1;
    #1 d = hst_rdata;
    hst_rd = 1'b0;
  endtask

  task automatic pulse_si();
    @(negedge clk); eng_si_set = 1'b1;
    @(negedge clk); eng_si_set = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hread(2'd0, rd); chk("R1 status", rd, 8'hF8);
    hread(2'd1, rd); chk("R1 data", rd, 8'h00);
    hread(2'd2, rd); chk("R1 own", rd, 8'h00);
    hread(2'd3, rd); chk("R1 ctrl", rd, 8'h00);
    chk("R1 timeout", cfg_timeout, 8'hFF);
    chk("R1 irq_n", irq_n, 1'b1);
    chk("R1 eng_ready", eng_ready, 1'b0);

    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) hwrite(VEC[i][17:16], VEC[i][15:8]);
      else begin
        hread(VEC[i][17:16], rd);
        chk($sformatf("R2 vector %0d", i), rd, VEC[i][7:0]);
      end
    end
    chk("R2 timeout written", cfg_timeout, 8'h5A);
    chk("R12 own addr", cfg_own_addr, 7'h52);
    @(negedge clk); #1 chk("R2 rdata idle", hst_rdata, 8'h00);

    // R3 field outputs
    hwrite(2'd3, 8'hA5);
    chk("R3 fields", {cfg_ack_en, cfg_enable, cfg_start, cfg_stop, cfg_si, cfg_rate},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5});

    // R5 ignored while disabled
    hwrite(2'd3, 8'h00);
    pulse_si();
    hread(2'd3, rd); chk("R5 si ignored when disabled", rd, 8'h00);
    chk("R11 hold when disabled", eng_hold, 1'b1);

    hwrite(2'd3, 8'h40);
    pulse_si();
    hread(2'd3, rd); chk("R5 si set", rd, 8'h48);
    chk("R7 irq_n low", irq_n, 1'b0);
    chk("R9 cap_ready low", eng_cap_ready, 1'b0);

    // R8 accepted with SI set; R9 capture blocked
    hwrite(2'd1, 8'h3C);
    hread(2'd1, rd); chk("R8 host data write with SI", rd, 8'h3C);
    @(negedge clk); eng_cap_valid = 1'b1; eng_cap_data = 8'hEE;
    @(negedge clk); eng_cap_valid = 1'b0;
    hread(2'd1, rd); chk("R9 data frozen while SI", rd, 8'h3C);

    // R4 write clears SI
    hwrite(2'd3, 8'h48);
    hread(2'd3, rd); chk("R4 si cleared by write", rd, 8'h40);
    chk("R7 irq_n released", irq_n, 1'b1);
    chk("R9 cap_ready high", eng_cap_ready, 1'b1);

    // R9 capture, R8 ignored write
    @(negedge clk); eng_cap_valid = 1'b1; eng_cap_data = 8'hC3;
    @(negedge clk); eng_cap_valid = 1'b0;
    hread(2'd1, rd); chk("R9 capture", rd, 8'hC3);
    hwrite(2'd1, 8'h11);
    hread(2'd1, rd); chk("R8 host write ignored", rd, 8'hC3);

    // R6 stop clear
    hwrite(2'd3, 8'h50);
    hread(2'd3, rd); chk("R6 stop set", rd, 8'h50);
    @(negedge clk); eng_sto_clr = 1'b1;
    @(negedge clk); eng_sto_clr = 1'b0;
    hread(2'd3, rd); chk("R6 stop cleared", rd, 8'h40);
    @(negedge clk);
    hst_addr = 2'd3; hst_wdata = 8'h50; hst_wr = 1'b1; eng_sto_clr = 1'b1;
    @(negedge clk); hst_wr = 1'b0; eng_sto_clr = 1'b0;
    hread(2'd3, rd); chk("R6 clear beats write", rd, 8'h40);

    // R4 set beats write-clear
    @(negedge clk);
    hst_addr = 2'd3; hst_wdata = 8'h40; hst_wr = 1'b1; eng_si_set = 1'b1;
    @(negedge clk); hst_wr = 1'b0; eng_si_set = 1'b0;
    hread(2'd3, rd); chk("R4 si_set wins", rd, 8'h48);
    hwrite(2'd3, 8'h40);

    // R10 status
    @(negedge clk); eng_stat_we = 1'b1; eng_stat = 8'h08;
    @(negedge clk); eng_stat_we = 1'b0;
    hread(2'd0, rd); chk("R10 status load", rd, 8'h08);
    hwrite(2'd0, 8'h33);
    hread(2'd0, rd); chk("R10 status host ro", rd, 8'h08);
    chk("R2 timeout via addr0", cfg_timeout, 8'h33);

    // R11 start-up timing
    chk("R11 ready after long enable", eng_ready, 1'b1);
    hwrite(2'd3, 8'h00);
    chk("R11 ready drops", eng_ready, 1'b0);
    hwrite(2'd3, 8'h40);
    chk("R11 hold released", eng_hold, 1'b0);
    for (int i = 1; i < N; i++) begin
      @(negedge clk);
      chk($sformatf("R11 not ready at %0d", i), eng_ready, 1'b0);
    end
    @(negedge clk);
    chk("R11 ready at count", eng_ready, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule